// File: doc/BRIEF.md
# Row-Aware DDR Access Scheduler

This block sits inside a memory controller whose external data bus is shared by reads and writes. It watches the heads of a read-request address queue and a write-request address queue (25-bit addresses, whose upper 15 bits name the row) and decides, one four-word access at a time, which direction uses the bus next. It keeps track of the row that is open in the memory and emits abstract commands (open row, read burst, write burst, close row, refresh) on a single command port. Fixed cycle counts stand in for the memory's row-open, row-close and refresh times. A four-word access moves two words per cycle, so a burst occupies two cycles.

The controller is a five-state machine. IDLE (no row open) goes to REFRESH when a refresh is requested, or to OPEN when either side has eligible work. OPEN waits its fixed delay and goes to BURST. At the last beat of a BURST, the machine goes back to the start of BURST when the next chosen access hits the open row, or to CLOSE on a refresh request, a row miss or an empty workload. CLOSE goes to REFRESH when the close was caused by a refresh, otherwise to IDLE. REFRESH returns to IDLE. A 32-bit signed-free wrapping counter tracks completed writes minus completed reads and has its own asynchronous clear.

Top module: `ddr_access_sched`

## Requirements
- R1: While and directly after reset the command port shows NOP (code 0), both pop outputs and ref_ack are low, and the access counter reads 0.
- R2: A read is eligible only when rd_addr_valid and rd_room are both high; a write is eligible only when wr_addr_valid is high and wr_rise_lvl, wr_fall_lvl and wr_mask_lvl are each at least 2. Work that is not eligible issues no command and pops nothing.
- R3: From IDLE with eligible work, OPEN (code 1) is issued the next cycle, the burst command (READ code 2, WRITE code 3) follows 3 cycles after OPEN, and the matching address pop is high in that same cycle; the burst lasts 2 cycles, and cmd_row carries bits 24..10 of the opened address.
- R4: When the access chosen at the last beat of a burst has the same row as the open row, its burst command is issued in the very next cycle, with no OPEN or CLOSE between.
- R5: When the chosen next access has a different row, CLOSE (code 4) is issued in the cycle after the burst, IDLE is reached after 2 close cycles, and OPEN follows one cycle later.
- R6: When both directions are eligible, the direction opposite to the most recent burst is chosen; after reset a read wins.
- R7: When no work is eligible at the last beat of a burst, the row is closed at once; OPEN is never issued while a row is open.
- R8: A refresh request takes priority: from IDLE REFRESH (code 5) is issued the next cycle ahead of any pending access; at the end of a burst the row is closed and REFRESH follows directly after the close; ref_ack is high in the cycle REFRESH is issued, which lasts 4 cycles.
- R9: The access counter rises by one after each write burst and falls by one after each read burst, updating on the clock edge that ends the burst, and wraps in both directions.
- R10: cnt_clr clears the counter immediately, without waiting for a clock edge, and holds it at 0 while high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_clr | input | 1 | Active-high asynchronous clear of the access counter |
| refresh_req | input | 1 | Refresh wanted; held until ref_ack |
| rd_addr_valid | input | 1 | Read address queue is not empty |
| rd_addr | input | 25 | Head of the read address queue |
| rd_room | input | 1 | Read data queues can take two more words each |
| wr_addr_valid | input | 1 | Write address queue is not empty |
| wr_addr | input | 25 | Head of the write address queue |
| wr_rise_lvl | input | 4 | Words held in the rising-edge write data queue |
| wr_fall_lvl | input | 4 | Words held in the falling-edge write data queue |
| wr_mask_lvl | input | 4 | Bytes held in the write mask queue |
| rd_pop | output | 1 | Remove the read address queue head |
| wr_pop | output | 1 | Remove the write address queue head |
| cmd_op | output | 3 | Command code: 0 NOP, 1 OPEN, 2 READ, 3 WRITE, 4 CLOSE, 5 REFRESH |
| cmd_row | output | 15 | Row the open row register holds |
| cmd_addr | output | 25 | Full address of a burst, valid with READ or WRITE |
| ref_ack | output | 1 | Refresh started |
| acc_count | output | 32 | Completed writes minus completed reads, wrapping |

## Verification
A wrong remembered row shows up within one burst as a missing or extra OPEN/CLOSE pair around a back-to-back burst, and a wrong last-direction bit shows as two bursts of the same direction while both sides wait. A delay counter that is off by one moves the burst command, and with it the address pop, by a cycle, which the per-cycle comparison against a behavioural model catches at once. A counter error is visible on acc_count one edge after the burst ends and persists, so the wrap values after the first read and first write expose it.

// File: rtl/ddr_sched_pkg.sv
package ddr_sched_pkg;

    typedef enum logic [2:0] {
        CMD_NOP     = 3'd0,
        CMD_OPEN    = 3'd1,
        CMD_READ    = 3'd2,
        CMD_WRITE   = 3'd3,
        CMD_CLOSE   = 3'd4,
        CMD_REFRESH = 3'd5
    } cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPEN,
        ST_BURST,
        ST_CLOSE,
        ST_REFRESH
    } state_e;

    typedef enum logic {
        DIR_RD = 1'b0,
        DIR_WR = 1'b1
    } dir_e;

endpackage

// File: rtl/sched_arbiter.sv
module sched_arbiter
    import ddr_sched_pkg::*;
#(
    parameter int ADDR_W  = 25,
    parameter int ROW_W   = 15,
    parameter int LVL_W   = 4,
    parameter int MIN_LVL = 2
) (
    input  logic              rd_valid,
    input  logic              rd_room,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              wr_valid,
    input  logic [LVL_W-1:0]  rise_lvl,
    input  logic [LVL_W-1:0]  fall_lvl,
    input  logic [LVL_W-1:0]  mask_lvl,
    input  logic [ADDR_W-1:0] wr_addr,
    input  dir_e              last_dir,
    output logic              any_ok,
    output dir_e              pick_dir,
    output logic [ROW_W-1:0]  pick_row
);
    localparam logic [LVL_W-1:0] NEED = LVL_W'(MIN_LVL);

    logic rd_ok;
    logic wr_ok;

    always_comb begin
        rd_ok  = rd_valid && rd_room;
        wr_ok  = wr_valid && (rise_lvl >= NEED) && (fall_lvl >= NEED)
                 && (mask_lvl >= NEED);
        any_ok = rd_ok || wr_ok;
        if (rd_ok && wr_ok) begin
            pick_dir = (last_dir == DIR_RD) ? DIR_WR : DIR_RD;
        end else if (wr_ok) begin
            pick_dir = DIR_WR;
        end else begin
            pick_dir = DIR_RD;
        end
        pick_row = (pick_dir == DIR_WR) ? wr_addr[ADDR_W-1 -: ROW_W]
                                        : rd_addr[ADDR_W-1 -: ROW_W];
    end

endmodule

// File: rtl/acc_counter.sv
module acc_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    input  logic             dec,
    output logic [CNT_W-1:0] count
);
    always_ff @(posedge clk or negedge rst_n or posedge clr) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else if (inc) begin
            count <= count + CNT_W'(1);
        end else if (dec) begin
            count <= count - CNT_W'(1);
        end
    end
endmodule

// File: rtl/ddr_access_sched.sv
module ddr_access_sched
    import ddr_sched_pkg::*;
#(
    parameter int ADDR_W     = 25,
    parameter int ROW_W      = 15,
    parameter int LVL_W      = 4,
    parameter int CNT_W      = 32,
    parameter int WORDS      = 4,
    parameter int WORDS_PER  = 2,
    parameter int OPEN_CYC   = 3,
    parameter int CLOSE_CYC  = 2,
    parameter int REF_CYC    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_clr,
    input  logic              refresh_req,
    input  logic              rd_addr_valid,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_room,
    input  logic              wr_addr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [LVL_W-1:0]  wr_rise_lvl,
    input  logic [LVL_W-1:0]  wr_fall_lvl,
    input  logic [LVL_W-1:0]  wr_mask_lvl,
    output logic              rd_pop,
    output logic              wr_pop,
    output logic [2:0]        cmd_op,
    output logic [ROW_W-1:0]  cmd_row,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic              ref_ack,
    output logic [CNT_W-1:0]  acc_count
);
    localparam int BEATS   = WORDS / WORDS_PER;
    localparam int BEAT_W  = (BEATS > 1) ? $clog2(BEATS) : 1;
    localparam int MAX_CYC = (OPEN_CYC > CLOSE_CYC)
                             ? ((OPEN_CYC > REF_CYC) ? OPEN_CYC : REF_CYC)
                             : ((CLOSE_CYC > REF_CYC) ? CLOSE_CYC : REF_CYC);
    localparam int TMR_W   = $clog2(MAX_CYC + 1);
    localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BEATS - 1);
    localparam logic [TMR_W-1:0]  T_OPEN    = TMR_W'(OPEN_CYC - 1);
    localparam logic [TMR_W-1:0]  T_CLOSE   = TMR_W'(CLOSE_CYC - 1);
    localparam logic [TMR_W-1:0]  T_REF     = TMR_W'(REF_CYC - 1);

    state_e             state_q, state_d;
    logic [TMR_W-1:0]   tmr_q, tmr_d;
    logic [BEAT_W-1:0]  beat_q, beat_d;
    logic [ROW_W-1:0]   row_q, row_d;
    dir_e               dir_q, dir_d;
    dir_e               last_q, last_d;
    logic               ref_after_q, ref_after_d;

    logic               any_ok;
    dir_e               pick_dir;
    logic [ROW_W-1:0]   pick_row;
    logic               cnt_inc;
    logic               cnt_dec;

    sched_arbiter #(
        .ADDR_W  (ADDR_W),
        .ROW_W   (ROW_W),
        .LVL_W   (LVL_W),
        .MIN_LVL (BEATS)
    ) u_arb (
        .rd_valid (rd_addr_valid),
        .rd_room  (rd_room),
        .rd_addr  (rd_addr),
        .wr_valid (wr_addr_valid),
        .rise_lvl (wr_rise_lvl),
        .fall_lvl (wr_fall_lvl),
        .mask_lvl (wr_mask_lvl),
        .wr_addr  (wr_addr),
        .last_dir (last_q),
        .any_ok   (any_ok),
        .pick_dir (pick_dir),
        .pick_row (pick_row)
    );

    acc_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .inc   (cnt_inc),
        .dec   (cnt_dec),
        .count (acc_count)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            tmr_q       <= '0;
            beat_q      <= '0;
            row_q       <= '0;
            dir_q       <= DIR_RD;
            last_q      <= DIR_WR;
            ref_after_q <= 1'b0;
        end else begin
            state_q     <= state_d;
            tmr_q       <= tmr_d;
            beat_q      <= beat_d;
            row_q       <= row_d;
            dir_q       <= dir_d;
            last_q      <= last_d;
            ref_after_q <= ref_after_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d     = state_q;
        tmr_d       = tmr_q;
        beat_d      = beat_q;
        row_d       = row_q;
        dir_d       = dir_q;
        last_d      = last_q;
        ref_after_d = ref_after_q;
        unique case (state_q)
            ST_IDLE: begin
                if (refresh_req) begin
                    state_d = ST_REFRESH;
                    tmr_d   = T_REF;
                end else if (any_ok) begin
                    state_d = ST_OPEN;
                    tmr_d   = T_OPEN;
                    row_d   = pick_row;
                    dir_d   = pick_dir;
                end
            end
            ST_OPEN: begin
                if (tmr_q == '0) begin
                    state_d = ST_BURST;
                    beat_d  = '0;
                end else begin
                    tmr_d = tmr_q - TMR_W'(1);
                end
            end
            ST_BURST: begin
                if (beat_q == '0) begin
                    last_d = dir_q;
                end
                if (beat_q != LAST_BEAT) begin
                    beat_d = beat_q + BEAT_W'(1);
                end else begin
                    beat_d = '0;
                    if (refresh_req) begin
                        state_d     = ST_CLOSE;
                        tmr_d       = T_CLOSE;
                        ref_after_d = 1'b1;
                    end else if (any_ok && (pick_row == row_q)) begin
                        dir_d = pick_dir;
                    end else begin
                        state_d     = ST_CLOSE;
                        tmr_d       = T_CLOSE;
                        ref_after_d = 1'b0;
                    end
                end
            end
            ST_CLOSE: begin
                if (tmr_q == '0) begin
                    if (ref_after_q) begin
                        state_d     = ST_REFRESH;
                        tmr_d       = T_REF;
                        ref_after_d = 1'b0;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end else begin
                    tmr_d = tmr_q - TMR_W'(1);
                end
            end
            ST_REFRESH: begin
                if (tmr_q == '0) begin
                    state_d = ST_IDLE;
                end else begin
                    tmr_d = tmr_q - TMR_W'(1);
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        cmd_op   = CMD_NOP;
        rd_pop   = 1'b0;
        wr_pop   = 1'b0;
        ref_ack  = 1'b0;
        cmd_addr = '0;
        cnt_inc  = 1'b0;
        cnt_dec  = 1'b0;
        cmd_row  = row_q;
        unique case (state_q)
            ST_IDLE: ;
            ST_OPEN: begin
                if (tmr_q == T_OPEN) cmd_op = CMD_OPEN;
            end
            ST_BURST: begin
                if (beat_q == '0) begin
                    cmd_op   = (dir_q == DIR_WR) ? CMD_WRITE : CMD_READ;
                    rd_pop   = (dir_q == DIR_RD);
                    wr_pop   = (dir_q == DIR_WR);
                    cmd_addr = (dir_q == DIR_WR) ? wr_addr : rd_addr;
                end
                if (beat_q == LAST_BEAT) begin
                    cnt_inc = (dir_q == DIR_WR);
                    cnt_dec = (dir_q == DIR_RD);
                end
            end
            ST_CLOSE: begin
                if (tmr_q == T_CLOSE) cmd_op = CMD_CLOSE;
            end
            ST_REFRESH: begin
                if (tmr_q == T_REF) begin
                    cmd_op  = CMD_REFRESH;
                    ref_ack = 1'b1;
                end
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/ddr_access_sched_chk.sv
module ddr_access_sched_chk #(
    parameter int ADDR_W = 25,
    parameter int CNT_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cnt_clr,
    input logic              refresh_req,
    input logic              rd_addr_valid,
    input logic              rd_room,
    input logic              wr_addr_valid,
    input logic              rd_pop,
    input logic              wr_pop,
    input logic [2:0]        cmd_op,
    input logic              ref_ack,
    input logic [CNT_W-1:0]  acc_count
);
    logic row_is_open;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row_is_open <= 1'b0;
        end else if (cmd_op == 3'd1) begin
            row_is_open <= 1'b1;
        end else if (cmd_op == 3'd4) begin
            row_is_open <= 1'b0;
        end
    end

    a_r3_single_pop: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_pop, wr_pop}));

    a_r2_read_pop_needs_entry: assert property (@(posedge clk) disable iff (!rst_n)
        rd_pop |-> (rd_addr_valid && rd_room));

    a_r2_write_pop_needs_entry: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pop |-> wr_addr_valid);

    a_r4_burst_in_open_row: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd_op == 3'd2) || (cmd_op == 3'd3)) |-> row_is_open);

    a_r7_no_double_open: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op == 3'd1) |-> !row_is_open);

    a_r8_refresh_row_closed: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op == 3'd5) |-> !row_is_open);

    a_r8_ack_was_requested: assert property (@(posedge clk) disable iff (!rst_n)
        ref_ack |-> $past(refresh_req));

    a_r9_count_steps_by_one: assert property (@(posedge clk) disable iff (!rst_n || cnt_clr)
        (acc_count == $past(acc_count)) || (acc_count == $past(acc_count) + CNT_W'(1))
        || (acc_count == $past(acc_count) - CNT_W'(1)));

endmodule

bind ddr_access_sched ddr_access_sched_chk #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cnt_clr       (cnt_clr),
    .refresh_req   (refresh_req),
    .rd_addr_valid (rd_addr_valid),
    .rd_room       (rd_room),
    .wr_addr_valid (wr_addr_valid),
    .rd_pop        (rd_pop),
    .wr_pop        (wr_pop),
    .cmd_op        (cmd_op),
    .ref_ack       (ref_ack),
    .acc_count     (acc_count)
);

// File: tb/test_ddr_access_sched.sv
module test_ddr_access_sched;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        b_clr = 1'b0;
    logic        b_ref = 1'b0;
    logic        b_rd_valid = 1'b0;
    logic [24:0] b_rd_addr = '0;
    logic        b_rd_room = 1'b1;
    logic        b_wr_valid = 1'b0;
    logic [24:0] b_wr_addr = '0;
    logic [3:0]  b_rise = 4'd8;
    logic [3:0]  b_fall = 4'd8;
    logic [3:0]  b_mask = 4'd8;

    logic        rd_pop, wr_pop, ref_ack;
    logic [2:0]  cmd_op;
    logic [14:0] cmd_row;
    logic [24:0] cmd_addr;
    logic [31:0] acc_count;

    ddr_access_sched i_ddr_access_sched (
        .clk           (clk),
        .rst_n         (rst_n),
        .cnt_clr       (b_clr),
        .refresh_req   (b_ref),
        .rd_addr_valid (b_rd_valid),
        .rd_addr       (b_rd_addr),
        .rd_room       (b_rd_room),
        .wr_addr_valid (b_wr_valid),
        .wr_addr       (b_wr_addr),
        .wr_rise_lvl   (b_rise),
        .wr_fall_lvl   (b_fall),
        .wr_mask_lvl   (b_mask),
        .rd_pop        (rd_pop),
        .wr_pop        (wr_pop),
        .cmd_op        (cmd_op),
        .cmd_row       (cmd_row),
        .cmd_addr      (cmd_addr),
        .ref_ack       (ref_ack),
        .acc_count     (acc_count)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int          checks = 0;
    int          failures = 0;
    bit          finished = 0;
    string       cur_req = "R1";
    string       cmd_log = "";
    logic [24:0] rq[$];
    logic [24:0] wq[$];
    bit          pend_rd = 0;
    bit          pend_wr = 0;
    bit          saw_read = 0;
    int          cyc = 0;
    int          burst_cyc[$];

    // behavioural model: 0 idle, 1 open, 2 burst, 3 close, 4 refresh
    int          m_state = 0;
    int          m_left = 0;
    int          m_beat = 0;
    logic [14:0] m_row = '0;
    bit          m_dir = 0;
    bit          m_last = 1;
    bit          m_refafter = 0;
    logic [31:0] m_count = '0;

    function automatic logic [24:0] mk(input int row, input int col);
        return {15'(row), 10'(col)};
    endfunction

    task automatic check(input bit ok, input string req, input string act, input string exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%s expected=%s", req, act, exp);
        end
    endtask

    task automatic drive_in();
        b_rd_valid = (rq.size() > 0);
        b_rd_addr  = (rq.size() > 0) ? rq[0] : '0;
        b_wr_valid = (wq.size() > 0);
        b_wr_addr  = (wq.size() > 0) ? wq[0] : '0;
    endtask

    task automatic model_step();
        bit          rd_ok, wr_ok, any, pdir;
        logic [14:0] prow;
        rd_ok = b_rd_valid && b_rd_room;
        wr_ok = b_wr_valid && (b_rise >= 2) && (b_fall >= 2) && (b_mask >= 2);
        any   = rd_ok || wr_ok;
        pdir  = (rd_ok && wr_ok) ? !m_last : wr_ok;
        prow  = pdir ? b_wr_addr[24:10] : b_rd_addr[24:10];
        case (m_state)
            0: begin
                if (b_ref) begin
                    m_state = 4; m_left = 4;
                end else if (any) begin
                    m_state = 1; m_left = 3; m_row = prow; m_dir = pdir;
                end
            end
            1: begin
                m_left--;
                if (m_left == 0) begin m_state = 2; m_beat = 0; end
            end
            2: begin
                if (m_beat == 0) begin
                    m_last = m_dir; m_beat = 1;
                end else begin
                    m_beat = 0;
                    if (m_dir) m_count = m_count + 1; else m_count = m_count - 1;
                    if (b_ref) begin
                        m_state = 3; m_left = 2; m_refafter = 1;
                    end else if (any && prow == m_row) begin
                        m_dir = pdir;
                    end else begin
                        m_state = 3; m_left = 2; m_refafter = 0;
                    end
                end
            end
            3: begin
                m_left--;
                if (m_left == 0) begin
                    if (m_refafter) begin
                        m_state = 4; m_left = 4; m_refafter = 0;
                    end else begin
                        m_state = 0;
                    end
                end
            end
            default: begin
                m_left--;
                if (m_left == 0) m_state = 0;
            end
        endcase
        if (b_clr) m_count = '0;
    endtask

    task automatic compare();
        logic [2:0]  e_cmd;
        logic [24:0] e_addr;
        bit          e_rp, e_wp, e_ack;
        bit          ok;
        e_cmd = 3'd0; e_addr = '0; e_rp = 0; e_wp = 0; e_ack = 0;
        if (m_state == 1 && m_left == 3) e_cmd = 3'd1;
        if (m_state == 2 && m_beat == 0) begin
            e_cmd  = m_dir ? 3'd3 : 3'd2;
            e_rp   = !m_dir;
            e_wp   = m_dir;
            e_addr = m_dir ? b_wr_addr : b_rd_addr;
        end
        if (m_state == 3 && m_left == 2) e_cmd = 3'd4;
        if (m_state == 4 && m_left == 4) begin e_cmd = 3'd5; e_ack = 1; end
        ok = (cmd_op == e_cmd) && (rd_pop == e_rp) && (wr_pop == e_wp) &&
             (ref_ack == e_ack) && (cmd_addr == e_addr) && (acc_count == m_count) &&
             ((e_cmd == 3'd0) || (cmd_row == m_row));
        check(ok, cur_req,
              $sformatf("cmd=%0d rp=%0b wp=%0b ack=%0b addr=%h row=%h cnt=%h",
                        cmd_op, rd_pop, wr_pop, ref_ack, cmd_addr, cmd_row, acc_count),
              $sformatf("cmd=%0d rp=%0b wp=%0b ack=%0b addr=%h row=%h cnt=%h",
                        e_cmd, e_rp, e_wp, e_ack, e_addr, m_row, m_count));
    endtask

    always @(posedge clk) begin
        if (rst_n) model_step();
    end

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (pend_rd && rq.size() > 0) void'(rq.pop_front());
            if (pend_wr && wq.size() > 0) void'(wq.pop_front());
            drive_in();
            #1;
            compare();
            pend_rd = rd_pop;
            pend_wr = wr_pop;
            case (cmd_op)
                3'd1: cmd_log = {cmd_log, "O"};
                3'd2: begin cmd_log = {cmd_log, "R"}; burst_cyc.push_back(cyc); saw_read = 1; end
                3'd3: begin cmd_log = {cmd_log, "W"}; burst_cyc.push_back(cyc); end
                3'd4: cmd_log = {cmd_log, "C"};
                3'd5: cmd_log = {cmd_log, "F"};
                default: ;
            endcase
            if (ref_ack) b_ref = 1'b0;
            cyc++;
        end
    end

    task automatic step_to_drive();
        @(negedge clk);
        #2;
    endtask

    task automatic start_scn(input string req);
        step_to_drive();
        cur_req = req;
        cmd_log = "";
        burst_cyc.delete();
        saw_read = 0;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
        #2;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        checks++;
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        #1;
        check(cmd_op == 3'd0 && !rd_pop && !wr_pop && !ref_ack, "R1",
              $sformatf("cmd=%0d", cmd_op), "cmd=0 no pops");
        check(acc_count == 32'd0, "R1", $sformatf("%h", acc_count), "00000000");
        rst_n = 1'b1;
        settle(2);
        check(cmd_log == "", "R1", cmd_log, "");

        // R3, R7, R9: single read, auto close, counter wraps down
        start_scn("R3");
        rq.push_back(mk(5, 0)); drive_in();
        settle(20);
        check(cmd_log == "ORC", "R7", cmd_log, "ORC");
        check(acc_count == 32'hFFFF_FFFF, "R9", $sformatf("%h", acc_count), "ffffffff");

        // R9: single write, counter wraps up
        start_scn("R9");
        wq.push_back(mk(5, 4)); drive_in();
        settle(20);
        check(cmd_log == "OWC", "R3", cmd_log, "OWC");
        check(acc_count == 32'h0, "R9", $sformatf("%h", acc_count), "00000000");

        // R4: two reads in one row, no gap
        start_scn("R4");
        rq.push_back(mk(7, 0)); rq.push_back(mk(7, 4)); drive_in();
        settle(25);
        check(cmd_log == "ORRC", "R4", cmd_log, "ORRC");
        check(burst_cyc.size() == 2 && burst_cyc[1] - burst_cyc[0] == 2, "R4",
              $sformatf("%0d bursts", burst_cyc.size()), "gap of 2 cycles");

        // R5: two reads in different rows
        start_scn("R5");
        rq.push_back(mk(8, 0)); rq.push_back(mk(9, 0)); drive_in();
        settle(30);
        check(cmd_log == "ORCORC", "R5", cmd_log, "ORCORC");
        check(burst_cyc.size() == 2 && burst_cyc[1] - burst_cyc[0] == 8, "R5",
              $sformatf("%0d bursts", burst_cyc.size()), "8 cycles apart");

        // R6: both directions ready in one row, last burst was a read
        start_scn("R6");
        rq.push_back(mk(10, 0)); rq.push_back(mk(10, 8));
        wq.push_back(mk(10, 4)); wq.push_back(mk(10, 12)); drive_in();
        settle(30);
        check(cmd_log == "OWRWRC", "R6", cmd_log, "OWRWRC");
        check(acc_count == 32'hFFFF_FFFC, "R9", $sformatf("%h", acc_count), "fffffffc");

        // R2: write held back by a short mask queue
        start_scn("R2");
        b_mask = 4'd1;
        wq.push_back(mk(20, 0)); drive_in();
        settle(15);
        check(cmd_log == "", "R2", cmd_log, "");
        b_mask = 4'd2;
        settle(20);
        check(cmd_log == "OWC", "R2", cmd_log, "OWC");

        // R2: read held back by a full read data queue
        start_scn("R2");
        b_rd_room = 1'b0;
        rq.push_back(mk(21, 0)); drive_in();
        settle(15);
        check(cmd_log == "", "R2", cmd_log, "");
        b_rd_room = 1'b1;
        settle(20);
        check(cmd_log == "ORC", "R2", cmd_log, "ORC");

        // R8: refresh wins over a pending access in idle
        start_scn("R8");
        b_ref = 1'b1;
        rq.push_back(mk(30, 0)); drive_in();
        settle(25);
        check(cmd_log == "FORC", "R8", cmd_log, "FORC");

        // R8: refresh during a burst closes the row first
        start_scn("R8");
        rq.push_back(mk(31, 0)); rq.push_back(mk(31, 4)); drive_in();
        while (!saw_read) step_to_drive();
        b_ref = 1'b1;
        settle(30);
        check(cmd_log == "ORCFORC", "R8", cmd_log, "ORCFORC");
        check(acc_count == 32'hFFFF_FFF9, "R9", $sformatf("%h", acc_count), "fffffff9");

        // R10: asynchronous clear
        step_to_drive();
        cur_req = "R10";
        b_clr = 1'b1;
        #1;
        check(acc_count == 32'h0, "R10", $sformatf("%h", acc_count), "00000000");
        wq.push_back(mk(40, 0)); drive_in();
        settle(15);
        check(acc_count == 32'h0, "R10", $sformatf("%h", acc_count), "00000000");
        b_clr = 1'b0;
        wq.push_back(mk(41, 0)); drive_in();
        settle(20);
        check(acc_count == 32'h1, "R10", $sformatf("%h", acc_count), "00000001");

        finish_run();
    end

endmodule